// File: doc/BRIEF.md
# Auto-ranging shunt selector with settling hold-off

This block keeps a current-measurement front end on the most suitable of three shunt values. Three comparators report whether the amplified shunt signal is above the top of the present range, below the bottom of it, or whether the voltage across the shunt has climbed past its safe maximum. From these inputs the block drives two switch controls. Each switch puts a resistor in parallel with the shunt, so closing switches lowers the shunt value and widens the current range.

The block runs on a fast clock so that it reacts quickly to an over-range event. After each range change, however, the analog circuit needs time to settle. A down-counter is loaded with a programmable settle count on every change, and no ordinary step is taken until that counter has run out. This keeps the selector from racing to an extreme range and then oscillating. The burden-voltage alert overrides the hold-off and moves the shunt to its lowest value at once.

The block also reports the present range as an index. It keeps a sticky flag that records a range change since the last measurement snapshot, and the snapshot strobe clears that flag.

Top module: `shunt_autorange`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the block in the lowest-shunt range with the flag clear and the hold-off counter at zero. A step request that arrives just after reset is therefore acted on without delay.
- R2: The switch code {`sw_hi_o`,`sw_lo_o`} is 2'b00 for the highest shunt, 2'b01 for the middle shunt and 2'b11 for the lowest shunt. `range_o` is 0, 1 and 2 for these three ranges. The code 2'b10 never appears.
- R3: When the hold-off has run out and the synchronized over-limit input is high, the range moves one position toward the lowest shunt (00 to 01, 01 to 11).
- R4: When the hold-off has run out, the over-limit input is low and the synchronized under-limit input is high, the range moves one position toward the highest shunt (11 to 01, 01 to 00).
- R5: Every range change loads the counter with `settle_i`. After a change the next ordinary step comes no sooner than `settle_i`+1 cycles later. A `settle_i` of 0 allows a step on every cycle.
- R6: A synchronized alert moves the range to the lowest shunt in a single step, whatever the counter holds. It takes priority over both limit inputs.
- R7: When the over-limit and under-limit inputs are high together, the over-limit input decides the step.
- R8: Each of the three comparator inputs passes through a two-flop synchronizer. A level that is set before rising edge k changes the outputs at edge k+2, which is the third rising edge after the level is set.
- R9: `changed_o` goes high with every range change and stays high until a cycle with `snap_i` high and no range change clears it. When a change and a snapshot fall in the same cycle, the flag is left set.
- R10: A request that points past an extreme range has no effect. Over-limit at the lowest shunt, under-limit at the highest shunt, and alert at the lowest shunt leave the range unchanged and do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast controller clock |
| rst | input | 1 | Synchronous reset, active high |
| over_i | input | 1 | Comparator: signal above the upper limit of the range (asynchronous) |
| under_i | input | 1 | Comparator: signal below the lower limit of the range (asynchronous) |
| alert_i | input | 1 | Comparator: burden voltage above its maximum (asynchronous) |
| settle_i | input | CNT_W | Hold-off length in cycles, loaded on each range change |
| snap_i | input | 1 | Measurement snapshot strobe; clears the change flag |
| sw_lo_o | output | 1 | Switch control for the first parallel resistor (code bit 0) |
| sw_hi_o | output | 1 | Switch control for the second parallel resistor (code bit 1) |
| range_o | output | 2 | Present range: 0 highest shunt, 1 middle, 2 lowest shunt |
| changed_o | output | 1 | Sticky flag: range changed since the last snapshot |

## Verification
The selector is driven with a held under-limit level and a held over-limit level, each with a non-zero settle count. These patterns separate a correct hold-off spacing of `settle_i`+1 cycles from an off-by-one, and show that a request at an extreme is ignored. Both limit inputs high at the middle range tells the two priority orders apart. An alert raised during a long hold-off shows whether the counter is wrongly allowed to block the safety step. A zero settle count with alternating limits checks that no hidden hold-off remains. A long pseudo-random mix of all inputs and snapshot strobes, compared on every cycle against a behavioural model, exposes timing slips in the synchronizer and in the flag set/clear race.

// File: rtl/shunt_autorange.sv
module shunt_autorange #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             over_i,
  input  logic             under_i,
  input  logic             alert_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             snap_i,
  output logic             sw_lo_o,
  output logic             sw_hi_o,
  output logic [1:0]       range_o,
  output logic             changed_o
);

  localparam logic [1:0] CODE_HI  = 2'b00;
  localparam logic [1:0] CODE_LOW = 2'b11;

  logic [SYNC_STAGES-1:0] ov_q, un_q, al_q;
  logic                   ov_s, un_s, al_s;
  logic [1:0]             code_q, code_d;
  logic [CNT_W-1:0]       hold_q;
  logic                   load;
  logic                   flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= '0;
      un_q <= '0;
      al_q <= '0;
    end else begin
      ov_q <= {ov_q[SYNC_STAGES-2:0], over_i};
      un_q <= {un_q[SYNC_STAGES-2:0], under_i};
      al_q <= {al_q[SYNC_STAGES-2:0], alert_i};
    end
  end

  assign ov_s = ov_q[SYNC_STAGES-1];
  assign un_s = un_q[SYNC_STAGES-1];
  assign al_s = al_q[SYNC_STAGES-1];

  always_comb begin
    code_d = code_q;
    load   = 1'b0;
    if (al_s) begin
      if (code_q != CODE_LOW) begin
        code_d = CODE_LOW;
        load   = 1'b1;
      end
    end else if (hold_q == '0) begin
      if (ov_s) begin
        if (code_q != CODE_LOW) begin
          code_d = {code_q[0], 1'b1};
          load   = 1'b1;
        end
      end else if (un_s) begin
        if (code_q != CODE_HI) begin
          code_d = {1'b0, code_q[1]};
          load   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_LOW;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      code_q <= code_d;
      if (load)
        hold_q <= settle_i;
      else if (hold_q != '0)
        hold_q <= hold_q - 1'b1;
      if (load)
        flag_q <= 1'b1;
      else if (snap_i)
        flag_q <= 1'b0;
    end
  end

  assign sw_lo_o   = code_q[0];
  assign sw_hi_o   = code_q[1];
  assign range_o   = {code_q[1], code_q[0] & ~code_q[1]};
  assign changed_o = flag_q;

endmodule

// File: rtl/shunt_autorange_chk.sv
module shunt_autorange_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ov_s,
  input logic             un_s,
  input logic             al_s,
  input logic [1:0]       code_q,
  input logic [CNT_W-1:0] hold_q,
  input logic             changed_o
);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (code_q == 2'b11 && hold_q == '0 && !changed_o)); // R1
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) code_q != 2'b10); // R2
  AST_OVER_STEP: assert property (@(posedge clk) disable iff (rst)
    (!al_s && hold_q == '0 && ov_s && code_q == 2'b00) |=> code_q == 2'b01); // R3
  AST_UNDER_STEP: assert property (@(posedge clk) disable iff (rst)
    (!al_s && hold_q == '0 && !ov_s && un_s && code_q == 2'b01) |=> code_q == 2'b00); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!al_s && hold_q != '0) |=> $stable(code_q)); // R5
  AST_ALERT_JUMP: assert property (@(posedge clk) disable iff (rst) al_s |=> code_q == 2'b11); // R6
  AST_OVER_WINS: assert property (@(posedge clk) disable iff (rst)
    (!al_s && hold_q == '0 && ov_s && un_s && code_q == 2'b01) |=> code_q == 2'b11); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (al_s && code_q != 2'b11) |=> changed_o); // R9
  AST_EXTREME_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!al_s && !ov_s && code_q == 2'b00) |=> code_q == 2'b00); // R10

endmodule

bind shunt_autorange shunt_autorange_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ov_s(ov_s), .un_s(un_s), .al_s(al_s),
  .code_q(code_q), .hold_q(hold_q), .changed_o(changed_o)
);

// File: tb/test_shunt_autorange.sv
`timescale 1ns/1ps
module test_shunt_autorange;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic over_i = 1'b0, under_i = 1'b0, alert_i = 1'b0, snap_i = 1'b0;
  logic [CNT_W-1:0] settle_i = '0;
  logic sw_lo_o, sw_hi_o, changed_o;
  logic [1:0] range_o;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  int m_rng = 2, m_cnt = 0, m_flag = 0;
  bit s1o, s1u, s1a, s2o, s2u, s2a;

  always #2 clk = ~clk;

  shunt_autorange #(.CNT_W(CNT_W)) i_shunt_autorange (
    .clk(clk), .rst(rst), .over_i(over_i), .under_i(under_i), .alert_i(alert_i),
    .settle_i(settle_i), .snap_i(snap_i), .sw_lo_o(sw_lo_o), .sw_hi_o(sw_hi_o),
    .range_o(range_o), .changed_o(changed_o)
  );

  always @(posedge clk) begin
    bit moved;
    if (rst) begin
      m_rng = 2; m_cnt = 0; m_flag = 0;
      s1o = 0; s1u = 0; s1a = 0; s2o = 0; s2u = 0; s2a = 0;
    end else begin
      moved = 0;
      if (s2a) begin
        if (m_rng != 2) begin m_rng = 2; moved = 1; end
      end else if (m_cnt == 0) begin
        if (s2o) begin
          if (m_rng < 2) begin m_rng = m_rng + 1; moved = 1; end
        end else if (s2u) begin
          if (m_rng > 0) begin m_rng = m_rng - 1; moved = 1; end
        end
      end
      if (moved) m_cnt = int'(settle_i);
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (moved) m_flag = 1;
      else if (snap_i) m_flag = 0;
      s2o = s1o; s2u = s1u; s2a = s1a;
      s1o = over_i; s1u = under_i; s1a = alert_i;
    end
  end

  function automatic int code_of(int r);
    return (r == 0) ? 0 : (r == 1) ? 1 : 3;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check({tag, " model range"}, int'(range_o), m_rng);
      check("R2 switch code", int'({sw_hi_o, sw_lo_o}), code_of(m_rng));
      check({tag, " R9 model flag"}, int'(changed_o), m_flag);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    tick(2);
    rst = 1'b0;
    cmp_on = 1'b1;
    check("R1 reset range", int'(range_o), 2);
    check("R1 reset flag", int'(changed_o), 0);
    check("R2 reset code", int'({sw_hi_o, sw_lo_o}), 3);

    tag = "R4/R8";
    settle_i = 12'd4;
    under_i = 1'b1;
    tick(2);
    check("R8 not yet after two edges", int'(range_o), 2);
    tick(1);
    check("R8 step on third edge", int'(range_o), 1);
    check("R9 flag set on change", int'(changed_o), 1);
    tag = "R5";
    tick(4);
    check("R5 held for settle cycles", int'(range_o), 1);
    tick(1);
    check("R5 step at settle+1", int'(range_o), 0);
    tag = "R10";
    tick(10);
    check("R10 under at highest shunt ignored", int'(range_o), 0);
    snap_i = 1'b1; tick(1); snap_i = 1'b0;
    check("R9 snapshot clears flag", int'(changed_o), 0);
    tick(6);
    check("R10 ignored request leaves flag clear", int'(changed_o), 0);
    under_i = 1'b0;

    tag = "R3";
    over_i = 1'b1;
    tick(3);
    check("R3 step toward lower shunt", int'(range_o), 1);
    tick(5);
    check("R3 second step after hold", int'(range_o), 2);
    tick(8);
    check("R10 over at lowest shunt ignored", int'(range_o), 2);
    over_i = 1'b0;
    tick(3);

    tag = "R7";
    settle_i = 12'd3;
    under_i = 1'b1;
    tick(3);
    check("R7 setup middle", int'(range_o), 1);
    over_i = 1'b1;
    tick(3);
    check("R7 hold before decision", int'(range_o), 1);
    tick(1);
    check("R7 over beats under", int'(range_o), 2);
    over_i = 1'b0; under_i = 1'b0;
    tick(8);

    tag = "R6";
    settle_i = 12'd200;
    under_i = 1'b1;
    tick(3);
    check("R6 setup middle with long hold", int'(range_o), 1);
    under_i = 1'b0;
    alert_i = 1'b1;
    tick(2);
    check("R6 alert still in synchronizer", int'(range_o), 1);
    tick(1);
    check("R6 alert overrides hold-off", int'(range_o), 2);
    alert_i = 1'b0;
    tick(205);

    tag = "R5 zero";
    settle_i = '0;
    under_i = 1'b1;
    tick(3);
    check("R5 zero settle first step", int'(range_o), 1);
    tick(1);
    check("R5 zero settle next cycle", int'(range_o), 0);
    under_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      over_i = i[0]; under_i = ~i[0];
      tick(1);
    end
    over_i = 1'b0; under_i = 1'b0;
    tick(4);

    tag = "R9 race";
    snap_i = 1'b1; tick(1); snap_i = 1'b0;
    under_i = (range_o != 2'd0);
    over_i  = (range_o == 2'd0);
    tick(2);
    snap_i = 1'b1; tick(1); snap_i = 1'b0;
    check("R9 change with snapshot keeps flag", int'(changed_o), 1);
    over_i = 1'b0; under_i = 1'b0;
    tick(4);

    tag = "R1 mid-run";
    rst = 1'b1; tick(1); rst = 1'b0;
    check("R1 reset mid-run range", int'(range_o), 2);
    check("R1 reset mid-run flag", int'(changed_o), 0);

    tag = "random R3/R4/R5/R6/R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      over_i   = lfsr[5] & lfsr[6];
      under_i  = lfsr[7] & lfsr[8];
      alert_i  = (lfsr[15:11] == 5'd0);
      snap_i   = lfsr[9] & lfsr[4];
      settle_i = {{(CNT_W-4){1'b0}}, lfsr[3:0]};
      tick(1);
    end
    over_i = 1'b0; under_i = 1'b0; alert_i = 1'b0; snap_i = 1'b0;
    tick(4);

    summary();
    $finish;
  end
endmodule